// File: doc/BRIEF.md
# Prioritized Memory Select Decoder

This block turns region-hit flags from external address comparators into chip selects for three internal targets on a microcontroller bus that keeps instruction fetches and data reads on separate strobes. The targets are an SRAM/IO region, a secondary boot flash and a main flash. When more than one comparator claims the same address, a fixed ranking picks one. The ranking is SRAM/IO first, then the boot flash, then the main flash.

An 8-bit mapping register decides which targets answer the code-fetch strobe and which answer the data-read strobe. A target can sit in either space or in both. The processor writes the register by a data write to a fixed address, so targets can be moved between spaces while the system runs. At reset the register loads a parameterised value. The chip selects are combinational from the strobes, the hit flags and the current register contents.

Top module: `memsel_decoder`

## Requirements
- R1: At reset the mapping register loads the parameter MAP_INIT with bits 6 and 5 forced to 0. No chip select is asserted while no strobe is active.
- R2: On the code-fetch strobe `code_rd`, register bit 0 allows SRAM, bit 1 allows the boot flash and bit 2 allows the main flash. A 0 in a bit blocks that target.
- R3: On the data-read strobe `data_rd`, bit 3 allows the boot flash and bit 4 allows the main flash. SRAM answers data reads and data writes whatever the register holds.
- R4: Among targets that the active strobes allow, the chip select follows the ranking SRAM > boot flash > main flash.
- R5: A target that is blocked for the active strobe does not hide an allowed target of lower rank.
- R6: At most one of `cs_sram`, `cs_boot` and `cs_main` is high in any cycle. None is high when no allowed target hits.
- R7: On the write strobe `data_wr`, both flashes can be selected regardless of register bits 0 to 4.
- R8: A data write with `addr == MAP_ADDR` loads `wdata` into the register at the clock edge that ends the cycle. The writing cycle is still decoded with the old contents. A write to any other address leaves the register unchanged.
- R9: Register bits 6 and 5 read as 0 on `map_value` and ignore writes. Bit 7 drives `io_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Bus address, compared with MAP_ADDR on writes |
| wdata | input | 8 | Write data for the mapping register |
| code_rd | input | 1 | Code-fetch strobe, active high |
| data_rd | input | 1 | Data-read strobe, active high |
| data_wr | input | 1 | Data-write strobe, active high |
| hit_sram | input | 1 | Comparator hit, SRAM/IO region |
| hit_boot | input | 1 | Comparator hit, boot flash region |
| hit_main | input | 1 | Comparator hit, main flash region |
| cs_sram | output | 1 | SRAM/IO chip select |
| cs_boot | output | 1 | Boot flash chip select |
| cs_main | output | 1 | Main flash chip select |
| io_mode | output | 1 | I/O port mode enable (register bit 7) |
| map_value | output | 8 | Current mapping register contents |

## Verification
Two functions can fall in the same cycle: a data write that rewrites the mapping register, and the chip-select decode. The bench provokes this with a register write whose cycle also asserts comparator hits. In that cycle it checks that the select follows the write rule and the old register contents. In the following cycle it checks that a code fetch is decoded with the new contents. The vector table covers each strobe against each target, with overlapping hits and with blocked higher-ranked targets.

// File: rtl/memsel_decoder.sv
module memsel_decoder #(
  parameter int         ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] MAP_ADDR = 16'h00B0,
  parameter logic [7:0] MAP_INIT = 8'hE7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              code_rd,
  input  logic              data_rd,
  input  logic              data_wr,
  input  logic              hit_sram,
  input  logic              hit_boot,
  input  logic              hit_main,
  output logic              cs_sram,
  output logic              cs_boot,
  output logic              cs_main,
  output logic              io_mode,
  output logic [7:0]        map_value
);

  localparam logic [7:0] KEEP = 8'h9F;

  logic [7:0] map_q;
  logic       ok_sram, ok_boot, ok_main;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      map_q <= MAP_INIT & KEEP;
    else if (data_wr && addr == MAP_ADDR)
      map_q <= wdata & KEEP;
  end

  assign ok_sram = (code_rd & map_q[0]) | data_rd | data_wr;
  assign ok_boot = (code_rd & map_q[1]) | (data_rd & map_q[3]) | data_wr;
  assign ok_main = (code_rd & map_q[2]) | (data_rd & map_q[4]) | data_wr;

  assign cs_sram = hit_sram & ok_sram;
  assign cs_boot = hit_boot & ok_boot & ~cs_sram;
  assign cs_main = hit_main & ok_main & ~cs_sram & ~cs_boot;

  assign io_mode   = map_q[7];
  assign map_value = map_q;

endmodule

module memsel_decoder_chk #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] MAP_ADDR = 16'h00B0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wdata,
  input logic              code_rd,
  input logic              data_rd,
  input logic              data_wr,
  input logic              hit_sram,
  input logic              hit_boot,
  input logic              hit_main,
  input logic              cs_sram,
  input logic              cs_boot,
  input logic              cs_main,
  input logic [7:0]        map_value
);

  p_one_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cs_sram, cs_boot, cs_main}));

  p_cs_needs_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_sram |-> hit_sram) and (cs_boot |-> hit_boot) and (cs_main |-> hit_main));

  p_sram_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_sram && (data_rd || data_wr)) |-> cs_sram);

  p_sram_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_sram |-> !cs_boot && !cs_main);

  p_code_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (code_rd && !data_rd && !data_wr && !map_value[2]) |-> !cs_main);

  p_flash_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && hit_boot && !hit_sram) |-> cs_boot);

  p_map_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && addr == MAP_ADDR) |=> map_value == ($past(wdata) & 8'h9F));

  p_map_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(data_wr && addr == MAP_ADDR) |=> $stable(map_value));

  p_unused_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    map_value[6:5] == 2'b00);

endmodule

bind memsel_decoder memsel_decoder_chk #(.ADDR_W(ADDR_W), .MAP_ADDR(MAP_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
  .code_rd(code_rd), .data_rd(data_rd), .data_wr(data_wr),
  .hit_sram(hit_sram), .hit_boot(hit_boot), .hit_main(hit_main),
  .cs_sram(cs_sram), .cs_boot(cs_boot), .cs_main(cs_main),
  .map_value(map_value)
);

// File: tb/memsel_decoder_tb.sv
module memsel_decoder_tb;
  localparam logic [15:0] MAP_ADDR = 16'h00B0;
  localparam logic [7:0]  MAP_INIT = 8'hE7;

  logic clk = 0, rst_n = 0;
  logic [15:0] addr = 0;
  logic [7:0]  wdata = 0;
  logic code_rd = 0, data_rd = 0, data_wr = 0;
  logic hit_sram = 0, hit_boot = 0, hit_main = 0;
  logic cs_sram, cs_boot, cs_main, io_mode;
  logic [7:0] map_value;
  int checks = 0, errs = 0;
  bit done = 0;

  always #10 clk = ~clk;

  memsel_decoder #(.ADDR_W(16), .MAP_ADDR(MAP_ADDR), .MAP_INIT(MAP_INIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .code_rd(code_rd), .data_rd(data_rd), .data_wr(data_wr),
    .hit_sram(hit_sram), .hit_boot(hit_boot), .hit_main(hit_main),
    .cs_sram(cs_sram), .cs_boot(cs_boot), .cs_main(cs_main),
    .io_mode(io_mode), .map_value(map_value));

  // {req[3:0], map[7:0], strobes {code,drd,dwr}, hits {sram,boot,main}, expected cs {sram,boot,main}}
  localparam int NV = 14;
  localparam logic [20:0] VEC [NV] = '{
    {4'd4, 8'h1F, 3'b100, 3'b111, 3'b100},  // R4 all allowed, SRAM wins
    {4'd4, 8'h1F, 3'b100, 3'b011, 3'b010},  // R4 boot over main
    {4'd2, 8'h1F, 3'b100, 3'b001, 3'b001},  // R2 main on code
    {4'd5, 8'h1E, 3'b100, 3'b110, 3'b010},  // R5 SRAM blocked, boot shows
    {4'd5, 8'h1C, 3'b100, 3'b111, 3'b001},  // R5 two blocked, main shows
    {4'd6, 8'h18, 3'b100, 3'b111, 3'b000},  // R6 nothing allowed on code
    {4'd3, 8'h07, 3'b010, 3'b011, 3'b000},  // R3 flashes blocked on read
    {4'd3, 8'h00, 3'b010, 3'b100, 3'b100},  // R3 SRAM always on read
    {4'd3, 8'h10, 3'b010, 3'b011, 3'b001},  // R3 boot blocked, main allowed
    {4'd3, 8'h08, 3'b010, 3'b011, 3'b010},  // R3 boot allowed on read
    {4'd7, 8'h00, 3'b001, 3'b011, 3'b010},  // R7 write reaches boot
    {4'd7, 8'h00, 3'b001, 3'b001, 3'b001},  // R7 write reaches main
    {4'd3, 8'h00, 3'b001, 3'b100, 3'b100},  // R3 SRAM on write
    {4'd6, 8'h1F, 3'b010, 3'b000, 3'b000}   // R6 no hit, no select
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    {code_rd, data_rd, data_wr, hit_sram, hit_boot, hit_main} = '0;
    addr = 16'h1234;
  endtask

  task automatic write_map(input logic [7:0] v);
    @(negedge clk);
    idle();
    addr = MAP_ADDR; wdata = v; data_wr = 1;
    @(negedge clk);
    idle();
  endtask

  function automatic logic [7:0] cs3();
    return {5'b0, cs_sram, cs_boot, cs_main};
  endfunction

  initial begin
    #(20 * 20000);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    // R1 reset value, unused bits cleared
    chk("R1", map_value, MAP_INIT & 8'h9F);
    chk("R1", cs3(), 8'h00);
    chk("R9", {7'b0, io_mode}, 8'h01);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      logic [20:0] v;
      v = VEC[i];
      write_map(v[16:9]);
      {code_rd, data_rd, data_wr} = v[8:6];
      {hit_sram, hit_boot, hit_main} = v[5:3];
      #5;
      chk($sformatf("R%0d vec%0d", v[20:17], i), cs3(), {5'b0, v[2:0]});
      @(negedge clk);
      idle();
    end

    // R9 unused bits ignore writes, bit 7 drives io_mode
    write_map(8'hFF);
    chk("R9", map_value, 8'h9F);
    chk("R9", {7'b0, io_mode}, 8'h01);
    write_map(8'h60);
    chk("R9", map_value, 8'h00);
    chk("R9", {7'b0, io_mode}, 8'h00);

    // R8 write elsewhere leaves register unchanged
    write_map(8'h05);
    @(negedge clk);
    addr = 16'h00B1; wdata = 8'hFA; data_wr = 1;
    @(negedge clk);
    idle();
    chk("R8", map_value, 8'h05);

    // R8 write cycle decoded with old map, new map next cycle
    write_map(8'h00);
    @(negedge clk);
    addr = MAP_ADDR; wdata = 8'h04; data_wr = 1; hit_boot = 1; hit_main = 1;
    #5;
    chk("R8", map_value, 8'h00);
    chk("R8", cs3(), 8'h02);
    @(negedge clk);
    idle();
    chk("R8", map_value, 8'h04);
    code_rd = 1; hit_boot = 1; hit_main = 1;
    #5;
    chk("R8", cs3(), 8'h01);
    @(negedge clk);
    idle();

    // R2 code strobe bit 0 allows SRAM
    write_map(8'h01);
    code_rd = 1; hit_sram = 1; hit_main = 1;
    #5;
    chk("R2", cs3(), 8'h04);
    @(negedge clk);
    idle();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
    $finish;
  end
endmodule